// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM Controller

This block links a plain request port to a synchronous SRAM that needs no bus-turnaround cycle. Each cycle the user may present one request: a read, a write, or a four-beat read burst. The controller registers the command onto the memory pins in the next cycle. It holds write data back by the memory's own latency, so the data reaches the shared data bus in the exact cycle the memory samples it. Read data is captured and returned with a valid strobe. Reads and writes can follow one another in any order with no gap, and the data bus stays fully used.

A parameter selects between two memory timings. The pipelined timing has a latency of two clocks and the flow-through timing has a latency of one. The same latency applies to read data and to write data. The bidirectional data bus appears as three signals: data out, output enable and data in. The pad tristate sits outside the block.

Top module: `zbt_ctrl`

## Requirements
- R1: A request is accepted in a cycle where req_valid and req_ready are both high. Accepted requests may follow one another on consecutive cycles in any mix of reads and writes, with no idle cycle between them on the memory side.
- R2: One clock after a request is accepted, sram_ce_n is low, sram_addr carries the request address and sram_adv is low. sram_we_n is low for a write and high for a read. In a cycle with no command, sram_ce_n is high.
- R3: With PIPELINED=1, the memory returns read data in the second cycle after the one in which it sampled the read command. rd_valid is high, and rd_data holds that data, in the cycle that begins three clocks after the accepting edge.
- R4: With PIPELINED=1, sram_dq_oe is high and sram_dq_o carries the write data in exactly the second cycle after the command cycle. In every other cycle sram_dq_oe is low.
- R5: With PIPELINED=0, both delays shrink by one clock. Write data is driven in the cycle right after the command cycle, and rd_valid rises two clocks after the accepting edge.
- R6: A request with req_burst=1 and req_write=0 is a four-beat burst read. Its first command cycle carries the address with sram_adv low. The next three cycles carry sram_ce_n low, sram_we_n high and sram_adv high, and the memory then steps its address by one, modulo the address space. rd_valid is high on four consecutive cycles, returning base, base+1, base+2 and base+3 in that order.
- R7: req_ready is low during the three continuation cycles of a burst, and any request presented then is ignored. A write presented in that window leaves memory unchanged. req_burst has no effect on a write, which performs a single write.
- R8: The controller never has sram_dq_oe high in a cycle in which the memory is driving read data.
- R9: While rst_n is low: sram_ce_n is high, sram_adv is low, sram_dq_oe is low, rd_valid is low and req_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_burst | input | 1 | With a read, requests a four-beat burst |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | Write data |
| req_ready | output | 1 | Request can be accepted this cycle |
| rd_valid | output | 1 | rd_data holds a returned read beat |
| rd_data | output | DW | Returned read data |
| sram_ce_n | output | 1 | Command strobe, active low |
| sram_we_n | output | 1 | Low for write, high for read |
| sram_adv | output | 1 | Continue burst, memory advances its address |
| sram_addr | output | AW | Memory address |
| sram_dq_o | output | DW | Data bus, driven value |
| sram_dq_oe | output | 1 | Data bus output enable |
| sram_dq_i | input | DW | Data bus, received value |

## Verification
The hardest case to reach is a read and a write following each other on the bus with zero spacing. In that case the memory's read beat and the controller's late write data occupy adjacent cycles. Any mistake of one clock in either delay line then shows up as a collision or as data landing in the wrong beat. The stimulus runs dense, irregular read/write mixes in both timing variants at once against a behavioural memory that models the latency. This includes a write followed immediately by a read of the same address, and a write presented while a burst is still running. Every cycle, the bench compares the bus command, the output enable, the write data and the returned data with a scheduled expectation.

// File: rtl/zbt_ctrl.sv
module zbt_ctrl #(
  parameter int AW = 18,
  parameter int DW = 32,
  parameter int PIPELINED = 1,
  parameter int BURST_LEN = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          req_burst,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ready,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          sram_ce_n,
  output logic          sram_we_n,
  output logic          sram_adv,
  output logic [AW-1:0] sram_addr,
  output logic [DW-1:0] sram_dq_o,
  output logic          sram_dq_oe,
  input  logic [DW-1:0] sram_dq_i
);
  localparam int LAT = (PIPELINED != 0) ? 2 : 1;
  localparam int CW  = (BURST_LEN > 2) ? $clog2(BURST_LEN) : 1;

  logic [CW-1:0] beats_left;
  logic [LAT:0]  wv, rv;
  logic [DW-1:0] wd [LAT+1];
  logic          accept, cont;

  assign cont      = beats_left != '0;
  assign req_ready = !cont;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sram_ce_n  <= 1'b1;
      sram_we_n  <= 1'b1;
      sram_adv   <= 1'b0;
      sram_addr  <= '0;
      beats_left <= '0;
    end else if (accept) begin
      sram_ce_n  <= 1'b0;
      sram_we_n  <= !req_write;
      sram_adv   <= 1'b0;
      sram_addr  <= req_addr;
      beats_left <= (req_burst && !req_write) ? CW'(BURST_LEN - 1) : '0;
    end else if (cont) begin
      sram_ce_n  <= 1'b0;
      sram_we_n  <= 1'b1;
      sram_adv   <= 1'b1;
      beats_left <= beats_left - 1'b1;
    end else begin
      sram_ce_n  <= 1'b1;
      sram_we_n  <= 1'b1;
      sram_adv   <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wv <= '0;
      rv <= '0;
    end else begin
      wv <= {wv[LAT-1:0], accept && req_write};
      rv <= {rv[LAT-1:0], (accept && !req_write) || cont};
    end
  end

  for (genvar k = 0; k <= LAT; k++) begin : g_wd
    if (k == 0) begin : g_in
      always_ff @(posedge clk) wd[0] <= req_wdata;
    end else begin : g_sh
      always_ff @(posedge clk) wd[k] <= wd[k-1];
    end
  end

  assign sram_dq_oe = wv[LAT];
  assign sram_dq_o  = wd[LAT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rv[LAT];
      if (rv[LAT]) rd_data <= sram_dq_i;
    end
  end
endmodule

// File: rtl/zbt_ctrl_chk.sv
module zbt_ctrl_chk #(
  parameter int PIPELINED = 1
) (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic req_write,
  input logic req_burst,
  input logic sram_ce_n,
  input logic sram_we_n,
  input logic sram_adv,
  input logic sram_dq_oe,
  input logic rd_valid
);
  logic acc;
  assign acc = req_valid && req_ready;

  p_cmd_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (!sram_ce_n && !sram_adv && (sram_we_n == !$past(req_write))));

  p_burst_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_burst && !req_write) |=> !req_ready);

  p_adv_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sram_adv |-> (!sram_ce_n && sram_we_n));

  if (PIPELINED != 0) begin : g_pipe
    p_late_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && req_write) |-> ##3 sram_dq_oe);
    p_read_ret_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !req_write) |-> ##4 rd_valid);
    p_no_clash_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!sram_ce_n && sram_we_n) |-> ##2 !sram_dq_oe);
  end else begin : g_flow
    p_late_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && req_write) |-> ##2 sram_dq_oe);
    p_read_ret_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !req_write) |-> ##3 rd_valid);
    p_no_clash_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!sram_ce_n && sram_we_n) |-> ##1 !sram_dq_oe);
  end
endmodule

bind zbt_ctrl zbt_ctrl_chk #(.PIPELINED(PIPELINED)) u_chk (.*);

// File: tb/zbt_ctrl_bench.sv
module zbt_ctrl_lane #(
  parameter int PIPE = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic        req_burst,
  input  logic [5:0]  req_addr,
  input  logic [31:0] req_wdata,
  output int          n_chk,
  output int          n_err
);
  localparam int LAT = PIPE ? 2 : 1;
  logic        req_ready, rd_valid, ce_n, we_n, adv, oe;
  logic [31:0] rd_data, dq_o, dq_i;
  logic [5:0]  addr;
  logic        mdrv;
  logic [31:0] mq;

  assign dq_i = mdrv ? mq : 32'h0;

  zbt_ctrl #(.AW(6), .DW(32), .PIPELINED(PIPE)) u_zbt_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_burst(req_burst), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ready(req_ready), .rd_valid(rd_valid), .rd_data(rd_data),
    .sram_ce_n(ce_n), .sram_we_n(we_n), .sram_adv(adv), .sram_addr(addr),
    .sram_dq_o(dq_o), .sram_dq_oe(oe), .sram_dq_i(dq_i));

  logic [31:0] mem [64];
  logic [31:0] ref_mem [64];
  int          cyc;
  int          cont;
  logic        e_ce, e_we, e_adv;
  logic [5:0]  e_addr;
  logic        s_oe [16];
  logic [31:0] s_wd [16];
  logic        s_rv [16];
  logic [31:0] s_rd [16];
  logic        h_v [2];
  logic        h_w [2];
  logic [5:0]  h_a [2];
  logic [5:0]  baddr;

  initial begin
    n_chk = 0; n_err = 0; cyc = 0; cont = 0;
    e_ce = 1; e_we = 1; e_adv = 0; e_addr = 0; baddr = 0;
    mdrv = 0; mq = 0;
    for (int i = 0; i < 64; i++) begin mem[i] = 0; ref_mem[i] = 0; end
    for (int i = 0; i < 16; i++) begin s_oe[i] = 0; s_rv[i] = 0; s_wd[i] = 0; s_rd[i] = 0; end
    for (int i = 0; i < 2; i++) begin h_v[i] = 0; h_w[i] = 0; h_a[i] = 0; end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s lane%0d cycle %0d actual %h expected %h", tag, PIPE, cyc, act, exp);
    end
  endtask

  // scoreboard: expected port behaviour per cycle
  always @(posedge clk) begin
    if (rst_n) begin
      cyc = cyc + 1;
      if (req_valid && req_ready) begin
        e_ce = 0; e_we = !req_write; e_adv = 0; e_addr = req_addr;
        if (req_write) begin
          ref_mem[req_addr] = req_wdata;
          s_oe[(cyc + LAT) % 16] = 1;
          s_wd[(cyc + LAT) % 16] = req_wdata;
          cont = 0;
        end else begin
          for (int b = 0; b < (req_burst ? 4 : 1); b++) begin
            s_rv[(cyc + LAT + 1 + b) % 16] = 1;
            s_rd[(cyc + LAT + 1 + b) % 16] = ref_mem[6'(req_addr + b)];
          end
          cont = req_burst ? 3 : 0;
        end
      end else if (cont > 0) begin
        e_ce = 0; e_we = 1; e_adv = 1; cont = cont - 1;
      end else begin
        e_ce = 1; e_we = 1; e_adv = 0;
      end
    end
  end

  // behavioural memory with LAT-cycle read and write data timing
  always @(posedge clk) begin
    logic cv, cw;
    logic [5:0] ca;
    if (!rst_n) begin
      mdrv <= 0;
      for (int i = 0; i < 2; i++) h_v[i] = 0;
    end else begin
      if (h_v[LAT-1] && h_w[LAT-1]) mem[h_a[LAT-1]] = dq_o;
      cv = !ce_n; cw = !we_n; ca = addr;
      if (!ce_n && adv) begin baddr = baddr + 1; ca = baddr; cw = 0; end
      else if (!ce_n) baddr = addr;
      h_v[1] = h_v[0]; h_w[1] = h_w[0]; h_a[1] = h_a[0];
      h_v[0] = cv; h_w[0] = cw; h_a[0] = ca;
      mdrv <= h_v[LAT-1] && !h_w[LAT-1];
      mq   <= mem[h_a[LAT-1]];
    end
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      chk("R9 ce_n", 32'(ce_n), 1);
      chk("R9 adv", 32'(adv), 0);
      chk("R9 oe", 32'(oe), 0);
      chk("R9 rd_valid", 32'(rd_valid), 0);
      chk("R9 ready", 32'(req_ready), 1);
    end else begin
      chk("R1 R2 ce_n", 32'(ce_n), 32'(e_ce));
      if (!e_ce) begin
        chk("R2 we_n", 32'(we_n), 32'(e_we));
        chk("R6 adv", 32'(adv), 32'(e_adv));
        if (!e_adv) chk("R2 addr", 32'(addr), 32'(e_addr));
      end
      chk("R7 ready", 32'(req_ready), 32'(cont == 0));
      chk(PIPE ? "R4 oe" : "R5 oe", 32'(oe), 32'(s_oe[cyc % 16]));
      if (s_oe[cyc % 16]) chk(PIPE ? "R4 wdata" : "R5 wdata", dq_o, s_wd[cyc % 16]);
      chk(PIPE ? "R3 rd_valid" : "R5 rd_valid", 32'(rd_valid), 32'(s_rv[cyc % 16]));
      if (s_rv[cyc % 16]) chk(PIPE ? "R3 R6 rd_data" : "R5 R6 rd_data", rd_data, s_rd[cyc % 16]);
      chk("R8 contention", 32'(oe && mdrv), 0);
      s_oe[cyc % 16] = 0;
      s_rv[cyc % 16] = 0;
    end
  end
endmodule

module zbt_ctrl_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        req_valid = 0, req_write = 0, req_burst = 0;
  logic [5:0]  req_addr = 0;
  logic [31:0] req_wdata = 0;
  int          c0, e0, c1, e1;
  int          wdog = 0;
  bit          done = 0;

  always #5 clk = ~clk;

  zbt_ctrl_lane #(.PIPE(1)) u_pipe (.clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .req_write(req_write), .req_burst(req_burst), .req_addr(req_addr),
    .req_wdata(req_wdata), .n_chk(c0), .n_err(e0));
  zbt_ctrl_lane #(.PIPE(0)) u_flow (.clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .req_write(req_write), .req_burst(req_burst), .req_addr(req_addr),
    .req_wdata(req_wdata), .n_chk(c1), .n_err(e1));

  task automatic op(input logic v, input logic w, input logic b, input int a, input logic [31:0] d);
    @(negedge clk);
    #1;
    req_valid = v; req_write = w; req_burst = b; req_addr = 6'(a); req_wdata = d;
  endtask

  task automatic finish_run(input bit timeout);
    int tc, te;
    tc = c0 + c1; te = e0 + e1;
    if (timeout) begin
      tc++; te++;
      $display("FAIL watchdog: run did not complete, actual timeout expected completion");
    end
    $display("CHECKS %0d ERRORS %0d", tc, te);
    $finish;
  endtask

  always @(posedge clk) begin
    wdog <= wdog + 1;
    if (wdog > 5000 && !done) finish_run(1);
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    // R1: back-to-back writes to a burst region
    for (int i = 0; i < 4; i++) op(1, 1, 0, 4 + i, 32'h1000 + i);
    // write/write/read/write/read mix, no gaps
    op(1, 1, 0, 10, 32'hAAAA_0010);
    op(1, 1, 0, 11, 32'hAAAA_0011);
    op(1, 0, 0, 10, 0);
    op(1, 1, 0, 12, 32'hAAAA_0012);
    op(1, 0, 0, 11, 0);
    // R6 burst read at 4, R7 write during continuation is ignored
    op(1, 0, 1, 4, 0);
    op(1, 1, 0, 5, 32'hDEAD_BEEF);
    op(1, 1, 0, 5, 32'hDEAD_BEEF);
    op(1, 1, 1, 5, 32'hDEAD_BEEF);
    op(1, 0, 0, 5, 0);
    op(1, 0, 0, 12, 0);
    // write then read of the same address back to back
    op(1, 1, 0, 20, 32'h2020_2020);
    op(1, 0, 0, 20, 0);
    op(1, 0, 0, 21, 0);
    op(0, 0, 0, 0, 0);
    // R7: burst flag on a write performs a single write
    op(1, 1, 1, 30, 32'h3030_3030);
    op(1, 0, 0, 30, 0);
    op(1, 0, 0, 31, 0);
    // burst across top of address space
    op(1, 1, 0, 62, 32'h6262);
    op(1, 1, 0, 63, 32'h6363);
    op(1, 1, 0, 0, 32'h0A0A);
    op(1, 0, 1, 62, 0);
    op(0, 0, 0, 0, 0);
    op(0, 0, 0, 0, 0);
    op(0, 0, 0, 0, 0);
    // irregular dense mix
    for (int i = 0; i < 60; i++)
      op((i % 11) != 5, (i % 3) != 0, 0, (i * 7) % 64, 32'(i) * 32'h0101_0101 ^ 32'h5A5A_0000);
    op(1, 0, 1, 14, 0);
    op(1, 1, 0, 14, 32'h7777);
    op(0, 0, 0, 0, 0);
    op(0, 0, 0, 0, 0);
    op(1, 0, 0, 14, 0);
    op(1, 0, 1, 14, 0);
    op(0, 0, 0, 0, 0);
    repeat (10) @(negedge clk);
    done = 1;
    finish_run(0);
  end
endmodule